// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block watches 32 general-purpose input pins and turns activity on them into one interrupt request. Every pin has its own trigger setup. It can be level-sensitive with a chosen polarity, or edge-sensitive on rising edges, falling edges or both. It can also latch its event until software acknowledges it, or pass the detected signal straight through. A pin counts as active when its pending status bit and its enable bit are both set. The interrupt output is the OR of all active pins.

Software reaches the block through a 16-bit register port. The pins form two banks of sixteen, and every per-pin register exists once per bank. Pending bits are cleared by writing 1. A read-only priority register names the active pin to service, so a handler can dispatch without scanning the status words itself. Each input passes through a two-flop synchroniser before detection.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: addr_i[3:1] selects a register group and addr_i[0] selects the bank (0 = pins 0–15, 1 = pins 16–31). The groups are: 0 trigger type, 1 polarity, 2 rising-edge enable, 3 falling-edge enable, 4 hold, 5 interrupt enable, 6 pending status, 7 priority index (read-only, same value in both banks). Writes use we_i and take effect at the next rising clock edge. Reads are combinational on rdata_o. Groups 0–5 read back the last value written.
- R2: While rst_ni is low, every control register and status bit reads 0, irq_o is 0 and the priority index reads 16'h8000.
- R3: With type bit 0 (level), a polarity bit of 1 makes the pin's detected signal the synchronised input, and a polarity bit of 0 makes it the inverse of that input. A change applied to a pin reaches its status bit on the third rising clock edge after it is applied.
- R4: With type bit 1 and only the rising-edge enable set, a 0-to-1 input transition produces an event and a 1-to-0 transition does not.
- R5: With type bit 1 and only the falling-edge enable set, a 1-to-0 transition produces an event and a 0-to-1 transition does not.
- R6: With type bit 1 and both edge enables set, transitions in either direction produce an event.
- R7: With hold bit 0, the status bit takes the detected value on every clock. An edge event therefore shows for exactly one cycle, and a level follows the pin.
- R8: With hold bit 1, a status bit stays set until a register write puts 1 in that bit position of its status word. Bits written as 0 are left unchanged.
- R9: When an event and a write-1 clear hit the same held status bit on the same clock edge, the bit stays set.
- R10: irq_o is high exactly when some pin has both its status bit and its enable bit set. It responds combinationally to enable writes.
- R11: The priority index carries in bits [4:0] the lowest-numbered active pin of the low bank. A high-bank pin (reported as 16–31) is given only when no low-bank pin is active. With no active pin the index reads 16'h8000.
- R12: Pin n ≥ 16 appears at bit n−16 of the high-bank word of every group. It has no effect on low-bank words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Asynchronous interrupt pins |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address (group, bank) |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data, combinational on addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench probes the status path at the exact edge where an input change should land, so a synchroniser that is one stage short or long shows up as a value seen a cycle early or late. Edge-mode tests drive transitions in the direction that is not enabled. They catch an edge detector with swapped or merged rise and fall terms, which would flag the wrong transition. A clear is timed to coincide with a fresh event, which exposes a status update that gives the clear priority and loses the event. Priority tests place an active low-bank pin at a higher bit position than an active high-bank pin, so an encoder that searches the banks in the wrong order, or that ignores enables, returns the wrong index.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DEF_BANK_W = 16;
  localparam int ADDR_W     = 4;

  typedef enum logic [2:0] {
    GRP_MODE = 3'd0,
    GRP_POL  = 3'd1,
    GRP_RISE = 3'd2,
    GRP_FALL = 3'd3,
    GRP_HOLD = 3'd4,
    GRP_EN   = 3'd5,
    GRP_STAT = 3'd6,
    GRP_PRIO = 3'd7
  } reg_grp_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] det_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] edge_ev, lvl_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  // edge terms gated by their own enables; polarity only matters in level mode
  assign edge_ev = (rise_en_i & sync_i & ~prev_q) | (fall_en_i & ~sync_i & prev_q);
  assign lvl_ev  = ~(sync_i ^ pol_i);
  assign det_o   = (mode_i & edge_ev) | (~mode_i & lvl_ev);
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] det_i,
  input  logic [W-1:0] hold_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] status_d;

  // held bits: set wins over clear; pass-through bits track det
  assign status_d = (hold_i & (det_i | (status_o & ~clr_i))) | (~hold_i & det_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= status_d;
  end
endmodule

// File: rtl/gpio_irq_ff1.sv
module gpio_irq_ff1 #(
  parameter int W = 16,
  localparam int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic             found_o,
  output logic [POS_W-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) pos_o = POS_W'(i);
    end
  end

  assign found_o = |vec_i;
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
  parameter int BANK_W = 16,
  localparam int NUM_PINS = 2 * BANK_W,
  localparam int IDX_W = $clog2(NUM_PINS),
  localparam int POS_W = $clog2(BANK_W)
) (
  input  logic [NUM_PINS-1:0] active_i,
  output logic [BANK_W-1:0]   idx_o
);
  logic [1:0]       found;
  logic [POS_W-1:0] pos [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    gpio_irq_ff1 #(.W(BANK_W)) u_ff1 (
      .vec_i  (active_i[b*BANK_W +: BANK_W]),
      .found_o(found[b]),
      .pos_o  (pos[b])
    );
  end

  always_comb begin
    idx_o = '0;
    if (found[0])      idx_o[IDX_W-1:0] = IDX_W'(pos[0]);
    else if (found[1]) idx_o[IDX_W-1:0] = IDX_W'(pos[1]) + IDX_W'(BANK_W);
    else               idx_o[BANK_W-1]  = 1'b1;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int BANK_W      = DEF_BANK_W,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_PINS = 2 * BANK_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BANK_W-1:0]   wdata_i,
  output logic [BANK_W-1:0]   rdata_o,
  output logic                irq_o
);
  reg_grp_e grp;
  logic     bank;

  logic [NUM_PINS-1:0] mode_q, pol_q, rise_q, fall_q, hold_q, en_q;
  logic [NUM_PINS-1:0] sync_pin, det, status_q, clr_vec, active;
  logic [BANK_W-1:0]   prio_idx;

  assign grp  = reg_grp_e'(addr_i[3:1]);
  assign bank = addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      pol_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      hold_q <= '0;
      en_q   <= '0;
    end else if (we_i) begin
      for (int b = 0; b < 2; b++) begin
        if (int'(bank) == b) begin
          case (grp)
            GRP_MODE: mode_q[b*BANK_W +: BANK_W] <= wdata_i;
            GRP_POL:  pol_q [b*BANK_W +: BANK_W] <= wdata_i;
            GRP_RISE: rise_q[b*BANK_W +: BANK_W] <= wdata_i;
            GRP_FALL: fall_q[b*BANK_W +: BANK_W] <= wdata_i;
            GRP_HOLD: hold_q[b*BANK_W +: BANK_W] <= wdata_i;
            GRP_EN:   en_q  [b*BANK_W +: BANK_W] <= wdata_i;
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_clr
    assign clr_vec[b*BANK_W +: BANK_W] =
      (we_i && grp == GRP_STAT && int'(bank) == b) ? wdata_i : '0;
  end

  gpio_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_i),
    .sync_o (sync_pin)
  );

  gpio_irq_detect #(.W(NUM_PINS)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_pin),
    .mode_i   (mode_q),
    .pol_i    (pol_q),
    .rise_en_i(rise_q),
    .fall_en_i(fall_q),
    .det_o    (det)
  );

  gpio_irq_status #(.W(NUM_PINS)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .det_i   (det),
    .hold_i  (hold_q),
    .clr_i   (clr_vec),
    .status_o(status_q)
  );

  assign active = status_q & en_q;
  assign irq_o  = |active;

  gpio_irq_prio #(.BANK_W(BANK_W)) u_prio (
    .active_i(active),
    .idx_o   (prio_idx)
  );

  always_comb begin
    case (grp)
      GRP_MODE: rdata_o = mode_q  [int'(bank)*BANK_W +: BANK_W];
      GRP_POL:  rdata_o = pol_q   [int'(bank)*BANK_W +: BANK_W];
      GRP_RISE: rdata_o = rise_q  [int'(bank)*BANK_W +: BANK_W];
      GRP_FALL: rdata_o = fall_q  [int'(bank)*BANK_W +: BANK_W];
      GRP_HOLD: rdata_o = hold_q  [int'(bank)*BANK_W +: BANK_W];
      GRP_EN:   rdata_o = en_q    [int'(bank)*BANK_W +: BANK_W];
      GRP_STAT: rdata_o = status_q[int'(bank)*BANK_W +: BANK_W];
      default:  rdata_o = prio_idx;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int BANK_W = 16,
  localparam int NUM_PINS = 2 * BANK_W,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                irq_o,
  input logic [BANK_W-1:0]   prio_idx,
  input logic [NUM_PINS-1:0] active,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] hold_q,
  input logic [NUM_PINS-1:0] clr_vec,
  input logic [NUM_PINS-1:0] det,
  input logic [NUM_PINS-1:0] mode_q,
  input logic [NUM_PINS-1:0] rise_q,
  input logic [NUM_PINS-1:0] fall_q
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R10
  irq_vs_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !prio_idx[BANK_W-1]);

  // R11
  prio_points_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prio_idx[BANK_W-1] |-> active[prio_idx[IDX_W-1:0]]);

  // R4
  edge_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det & mode_q & ~(rise_q | fall_q)) == '0);

  // R7
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> ((status_q ^ $past(det)) & $past(~hold_q)) == '0);

  // R8
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> ($past(status_q & hold_q & ~clr_vec) & ~status_q) == '0);

  // R9
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> ($past(det & hold_q) & ~status_q) == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .prio_idx(prio_idx),
  .active  (active),
  .status_q(status_q),
  .hold_q  (hold_q),
  .clr_vec (clr_vec),
  .det     (det),
  .mode_q  (mode_q),
  .rise_q  (rise_q),
  .fall_q  (fall_q)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/100ps
module gpio_irq_ctrl_test;
  localparam logic [3:0] A_MODE_L = 4'd0,  A_POL_L = 4'd2,  A_RISE_L = 4'd4;
  localparam logic [3:0] A_FALL_L = 4'd6,  A_HOLD_L = 4'd8, A_EN_L = 4'd10;
  localparam logic [3:0] A_EN_H = 4'd11,   A_ST_L = 4'd12,  A_ST_H = 4'd13;
  localparam logic [3:0] A_PRIO = 4'd14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = 32'hFFFF_FFFF;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [3:0]  a;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];
  event  push_ev;

  always #10 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .pin_i  (pins),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  // monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      @(push_ev);
      while (exp_q.size() != 0) begin
        item_t it;
        logic [15:0] act;
        it  = exp_q.pop_front();
        act = it.is_irq ? {15'd0, irq} : rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, act, it.exp);
        end
      end
    end
  end

  task automatic chk_rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    addr = a;
    #0.4;
    it.is_irq = 1'b0; it.a = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    -> push_ev;
    #0.4;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    #0.4;
    it.is_irq = 1'b1; it.a = addr; it.exp = {15'd0, e}; it.tag = tag;
    exp_q.push_back(it);
    -> push_ev;
    #0.4;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R2 reset state
    step(3);
    chk_rd(A_ST_L, 16'h0000, "R2");
    chk_rd(A_ST_H, 16'h0000, "R2");
    chk_rd(A_EN_L, 16'h0000, "R2");
    chk_rd(A_PRIO, 16'h8000, "R2");
    chk_irq(1'b0, "R2");
    rst_n = 1'b1;
    step(5);
    chk_rd(A_ST_L, 16'h0000, "R3");
    chk_rd(A_ST_H, 16'h0000, "R3");

    // R1 readback of every control register
    for (int i = 0; i < 12; i++) begin
      logic [15:0] v;
      v = 16'hA5C3 ^ 16'(i * 16'h1111);
      wr(4'(i), v);
      chk_rd(4'(i), v, "R1");
    end
    for (int i = 0; i < 12; i++) wr(4'(i), 16'h0000);
    step(4);
    chk_rd(A_ST_L, 16'h0000, "R1");
    chk_rd(A_ST_H, 16'h0000, "R1");

    // R3 level polarity and latency
    pins[3] = 1'b0; step(3);
    chk_rd(A_ST_L, 16'h0008, "R3");
    wr(A_POL_L, 16'h0008); step(1);
    chk_rd(A_ST_L, 16'h0000, "R3");
    pins[3] = 1'b1; step(2);
    chk_rd(A_ST_L, 16'h0000, "R3");
    step(1);
    chk_rd(A_ST_L, 16'h0008, "R3");
    wr(A_POL_L, 16'h0000); step(1);
    chk_rd(A_ST_L, 16'h0000, "R3");

    // R4 rising only, held
    wr(A_MODE_L, 16'h0020); wr(A_HOLD_L, 16'h0020); wr(A_RISE_L, 16'h0020);
    step(2);
    pins[5] = 1'b0; step(3);
    chk_rd(A_ST_L, 16'h0000, "R4");
    pins[5] = 1'b1; step(3);
    chk_rd(A_ST_L, 16'h0020, "R4");
    step(5);
    chk_rd(A_ST_L, 16'h0020, "R8");
    pins[5] = 1'b0; step(3);
    chk_rd(A_ST_L, 16'h0020, "R8");
    // R8 write-one-to-clear
    wr(A_ST_L, 16'h0000);
    chk_rd(A_ST_L, 16'h0020, "R8");
    wr(A_ST_L, 16'hFFDF);
    chk_rd(A_ST_L, 16'h0020, "R8");
    wr(A_ST_L, 16'h0020);
    chk_rd(A_ST_L, 16'h0000, "R8");

    // R5 falling only
    wr(A_MODE_L, 16'h0060); wr(A_HOLD_L, 16'h0060); wr(A_FALL_L, 16'h0040);
    pins[6] = 1'b0; step(3);
    chk_rd(A_ST_L, 16'h0040, "R5");
    wr(A_ST_L, 16'h0040);
    chk_rd(A_ST_L, 16'h0000, "R5");
    pins[6] = 1'b1; step(3);
    chk_rd(A_ST_L, 16'h0000, "R5");

    // R6 both edges
    wr(A_MODE_L, 16'h00E0); wr(A_HOLD_L, 16'h00E0);
    wr(A_RISE_L, 16'h00A0); wr(A_FALL_L, 16'h00C0);
    pins[7] = 1'b0; step(3);
    chk_rd(A_ST_L, 16'h0080, "R6");
    wr(A_ST_L, 16'h0080);
    chk_rd(A_ST_L, 16'h0000, "R6");
    pins[7] = 1'b1; step(3);
    chk_rd(A_ST_L, 16'h0080, "R6");
    wr(A_ST_L, 16'h0080);
    chk_rd(A_ST_L, 16'h0000, "R6");

    // R7 pass-through edge pulse
    wr(A_MODE_L, 16'h01E0); wr(A_RISE_L, 16'h01A0);
    pins[8] = 1'b0; step(3);
    chk_rd(A_ST_L, 16'h0000, "R7");
    pins[8] = 1'b1; step(3);
    chk_rd(A_ST_L, 16'h0100, "R7");
    step(1);
    chk_rd(A_ST_L, 16'h0000, "R7");

    // R9 event coincides with clear
    wr(A_MODE_L, 16'h03E0); wr(A_HOLD_L, 16'h02E0); wr(A_RISE_L, 16'h03A0);
    pins[9] = 1'b0; step(3);
    chk_rd(A_ST_L, 16'h0000, "R9");
    pins[9] = 1'b1; step(3);
    chk_rd(A_ST_L, 16'h0200, "R9");
    pins[9] = 1'b0; step(3);
    chk_rd(A_ST_L, 16'h0200, "R9");
    pins[9] = 1'b1; step(2);
    wr(A_ST_L, 16'h0200);
    chk_rd(A_ST_L, 16'h0200, "R9");
    wr(A_ST_L, 16'h0200);
    chk_rd(A_ST_L, 16'h0000, "R9");

    // R12 / R10 / R11 high bank, enables and priority
    pins[20] = 1'b0; step(3);
    chk_rd(A_ST_H, 16'h0010, "R12");
    chk_rd(A_ST_L, 16'h0000, "R12");
    chk_irq(1'b0, "R10");
    chk_rd(A_PRIO, 16'h8000, "R11");
    wr(A_EN_H, 16'h0010);
    chk_irq(1'b1, "R10");
    chk_rd(A_PRIO, 16'h0014, "R11");
    pins[18] = 1'b0; step(3);
    chk_rd(A_ST_H, 16'h0014, "R12");
    chk_rd(A_PRIO, 16'h0014, "R11");
    wr(A_EN_H, 16'h0014);
    chk_rd(A_PRIO, 16'h0012, "R11");
    pins[15] = 1'b0; step(3);
    chk_rd(A_ST_L, 16'h8000, "R12");
    chk_rd(A_PRIO, 16'h0012, "R11");
    wr(A_EN_L, 16'h8000);
    chk_rd(A_PRIO, 16'h000F, "R11");
    pins[0] = 1'b0; step(3);
    wr(A_EN_L, 16'h8001);
    chk_rd(A_PRIO, 16'h0000, "R11");
    pins[0] = 1'b1; pins[15] = 1'b1; step(3);
    chk_rd(A_PRIO, 16'h0012, "R11");
    chk_irq(1'b1, "R10");
    pins[18] = 1'b1; pins[20] = 1'b1; step(3);
    chk_irq(1'b0, "R10");
    chk_rd(A_PRIO, 16'h8000, "R11");

    step(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule